// File: doc/BRIEF.md
# Legacy Memory Window Decoder

This block steers every access that falls in the upper legacy window below one megabyte (0xA0000 to 0xFFFFF) either to main DRAM or out to the expansion bus. Accesses anywhere else always go to DRAM. The decision is combinational. It depends on the access address, a read/write flag, the system-management-mode input and a small set of byte-wide attribute registers. Those registers are loaded through a simple write port that takes a byte offset and a data byte.

The window has three parts. The top 64 KB (0xF0000 to 0xFFFFF) has one 2-bit attribute. The area from 0xC0000 to 0xEFFFF is split into twelve 16 KB segments, each with its own 2-bit attribute. The video area from 0xA0000 to 0xBFFFF is controlled by a separate management-memory control byte. An attribute of 3 gives full DRAM access. An attribute of 1 makes the region read-only DRAM, so writes to it go to the bus. Any other attribute value sends the access to the bus.

Top module: `legacy_map_decoder`

## Requirements
- R1: Addresses below 0xA0000 or at or above 0x100000 give to_dram=1 for reads and writes, whatever the register contents.
- R2: After reset, the attribute bytes at offsets 0x59 to 0x5F are zero and the control byte at 0x72 is 0x02. As a result, every access in 0xA0000 to 0xFFFFF goes to the bus.
- R3: For 0xF0000 to 0xFFFFF, the attribute is bits 5:4 of the byte at offset 0x59.
- R4: Segment i (0 to 11) covers 0xC0000+0x4000*i up to the next 16 KB boundary. Its attribute is in the byte at offset 0x5A+(i>>1). An even i uses bits 1:0 and an odd i uses bits 5:4. Bits 3:2 and 7:6 have no effect.
- R5: Attribute 3 gives to_dram=1 for both reads and writes.
- R6: Attribute 1 gives to_dram=1 for reads and to_dram=0 for writes.
- R7: Attribute 0 or 2 gives to_dram=0 for reads and writes.
- R8: When bit 6 of the byte at 0x72 is clear, 0xA0000 to 0xBFFFF goes to DRAM only if bit 3 of that byte is set and smm_active=1. Otherwise it goes to the bus.
- R9: When bit 6 of the byte at 0x72 is set, 0xA0000 to 0xBFFFF goes to DRAM whatever smm_active is.
- R10: A register write takes effect on the clock edge that samples it. An access presented in the same cycle as the write is decoded with the old value, and the new value applies from the next cycle.
- R11: Writes to offsets other than 0x59 to 0x5F and 0x72 change no decode result.
- R12: to_bus is always the complement of to_dram.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 8 | Register write data |
| acc_addr | input | ADDR_W | Address of the access being decoded |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| smm_active | input | 1 | System management mode is active |
| to_dram | output | 1 | The access is served by DRAM |
| to_bus | output | 1 | The access is forwarded to the expansion bus |

## Verification
A register write and an access to the region that the write controls can occur in the same cycle. In that cycle the decode must still use the old attribute, and from the next cycle on it must use the new one. The bench provokes this by asserting a write to a segment's attribute byte while presenting a read of that same segment. It samples to_dram before the clock edge, where it expects the old bus result. It samples again one cycle later, where it expects the new DRAM result. The video area is checked the same way across changes of smm_active, with and without the override bit set.

// File: rtl/legacy_map_decoder.sv
module legacy_map_decoder #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              smm_active,
  output logic              to_dram,
  output logic              to_bus
);

  localparam logic [ADDR_W-1:0] VGA_LO  = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] OPT_LO  = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] TOP_LO  = ADDR_W'(32'h000F_0000);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(32'h0010_0000);
  localparam int NSEG_BYTES = 6;
  localparam logic [7:0] OFS_TOP  = 8'h59;
  localparam logic [7:0] OFS_SEG0 = 8'h5A;
  localparam logic [7:0] OFS_SMR  = 8'h72;

  logic [7:0] top_q;
  logic [7:0] smram_q;
  logic [7:0] seg_q [NSEG_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= 8'h00;
      smram_q <= 8'h02;
      for (int k = 0; k < NSEG_BYTES; k++) seg_q[k] <= 8'h00;
    end else if (cfg_we) begin
      if (cfg_addr == OFS_TOP) top_q <= cfg_wdata;
      if (cfg_addr == OFS_SMR) smram_q <= cfg_wdata;
      for (int k = 0; k < NSEG_BYTES; k++)
        if (cfg_addr == OFS_SEG0 + 8'(k)) seg_q[k] <= cfg_wdata;
    end
  end

  logic              in_vga, in_opt, in_top;
  logic [ADDR_W-1:0] opt_off;
  logic [3:0]        seg_idx;
  logic [7:0]        seg_byte;
  logic [1:0]        attr;
  logic              attr_dram, vga_open;

  assign in_vga  = (acc_addr >= VGA_LO) && (acc_addr < OPT_LO);
  assign in_opt  = (acc_addr >= OPT_LO) && (acc_addr < TOP_LO);
  assign in_top  = (acc_addr >= TOP_LO) && (acc_addr < WIN_END);
  assign opt_off = acc_addr - OPT_LO;
  assign seg_idx = opt_off[17:14];

  always_comb begin
    seg_byte = 8'h00;
    for (int k = 0; k < NSEG_BYTES; k++)
      if (seg_idx[3:1] == 3'(k)) seg_byte = seg_q[k];
  end

  assign attr      = in_top ? top_q[5:4] : (seg_idx[0] ? seg_byte[5:4] : seg_byte[1:0]);
  assign attr_dram = (attr == 2'b11) || (attr == 2'b01 && !acc_write);
  assign vga_open  = smram_q[6] | (smram_q[3] & smm_active);

  assign to_dram = in_vga ? vga_open : ((in_opt || in_top) ? attr_dram : 1'b1);
  assign to_bus  = ~to_dram;

  assert_outside_dram_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vga && !in_opt && !in_top) |-> to_dram);

  assert_top_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_TOP && cfg_wdata[5:4] == 2'b11) |=> (!in_top || to_dram));

  assert_ro_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_opt || in_top) && acc_write && to_dram) |-> (attr == 2'b11));

  assert_vga_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vga && !smram_q[6] && !smm_active) |-> to_bus);

  assert_vga_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vga && smram_q[6]) |-> to_dram);

  assert_smram_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == OFS_SMR) |=> (smram_q == $past(cfg_wdata)));

endmodule

// File: tb/tb_legacy_map_decoder.sv
module tb_legacy_map_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [31:0] acc_addr = 32'h0;
  logic        acc_write = 1'b0;
  logic        smm_active = 1'b0;
  logic        to_dram, to_bus;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_map_decoder #(.ADDR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
    .smm_active(smm_active), .to_dram(to_dram), .to_bus(to_bus));

  // {req, addr, write, smm, expected to_dram}
  localparam int NVEC = 17;
  localparam logic [38:0] VEC [NVEC] = '{
    {4'd1,  32'h0000_0000, 1'b0, 1'b0, 1'b1},  // R1
    {4'd1,  32'h0009_FFFF, 1'b1, 1'b0, 1'b1},  // R1
    {4'd1,  32'h0010_0000, 1'b1, 1'b0, 1'b1},  // R1
    {4'd6,  32'h000C_0000, 1'b0, 1'b0, 1'b1},  // R6 seg0 read
    {4'd6,  32'h000C_3FFF, 1'b1, 1'b0, 1'b0},  // R6 seg0 write
    {4'd5,  32'h000C_4000, 1'b1, 1'b0, 1'b1},  // R5 seg1
    {4'd5,  32'h000C_7FFF, 1'b0, 1'b0, 1'b1},  // R5 seg1
    {4'd7,  32'h000C_8000, 1'b0, 1'b0, 1'b0},  // R7 seg2 attr2
    {4'd7,  32'h000C_C000, 1'b1, 1'b0, 1'b0},  // R7 seg3 attr0
    {4'd4,  32'h000E_8000, 1'b1, 1'b0, 1'b1},  // R4 seg10 low nibble
    {4'd4,  32'h000E_C000, 1'b0, 1'b0, 1'b1},  // R4 seg11 high nibble read
    {4'd4,  32'h000E_FFFF, 1'b1, 1'b0, 1'b0},  // R4 seg11 write
    {4'd3,  32'h000F_0000, 1'b1, 1'b0, 1'b1},  // R3
    {4'd3,  32'h000F_FFFF, 1'b0, 1'b0, 1'b1},  // R3
    {4'd8,  32'h000A_0000, 1'b0, 1'b0, 1'b0},  // R8 no smm
    {4'd8,  32'h000B_FFFF, 1'b1, 1'b1, 1'b1},  // R8 smm
    {4'd4,  32'h000D_0000, 1'b0, 1'b0, 1'b0}   // R4 seg4 untouched
  };

  task automatic chk(input int req, input logic [31:0] a, input logic w,
                     input logic s, input logic exp);
    acc_addr = a; acc_write = w; smm_active = s;
    #1;
    n_checks++;
    if (to_dram !== exp || to_bus !== ~exp) begin
      n_fail++;
      $display("FAIL R%0d addr=%h wr=%0b smm=%0b: actual dram=%0b bus=%0b expected dram=%0b",
               req, a, w, s, to_dram, to_bus, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_checks++;
    $display("FAIL R10 watchdog: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    // R2 reset state, R12 complement checked in every call
    chk(2, 32'h000A_0000, 1'b0, 1'b1, 1'b0);
    chk(2, 32'h000C_0000, 1'b0, 1'b0, 1'b0);
    chk(2, 32'h000E_4000, 1'b1, 1'b0, 1'b0);
    chk(2, 32'h000F_8000, 1'b0, 1'b0, 1'b0);
    chk(12, 32'h0000_1000, 1'b0, 1'b0, 1'b1);

    wr_cfg(8'h59, 8'h30);
    wr_cfg(8'h5A, 8'h31);
    wr_cfg(8'h5B, 8'h02);
    wr_cfg(8'h5F, 8'h13);
    wr_cfg(8'h72, 8'h0A);
    for (int i = 0; i < NVEC; i++)
      chk(int'(VEC[i][38:35]), VEC[i][34:3], VEC[i][2], VEC[i][1], VEC[i][0]);

    // R4 bits 7:6 of an odd segment byte ignored (seg9 at 0xE4000)
    wr_cfg(8'h5E, 8'hCC);
    chk(4, 32'h000E_4000, 1'b0, 1'b0, 1'b0);
    chk(4, 32'h000E_0000, 1'b0, 1'b0, 1'b0);

    // R9 override opens video area without smm
    wr_cfg(8'h72, 8'h40);
    chk(9, 32'h000A_8000, 1'b1, 1'b0, 1'b1);
    chk(9, 32'h000B_0000, 1'b0, 1'b1, 1'b1);
    wr_cfg(8'h72, 8'h02);
    chk(8, 32'h000A_8000, 1'b0, 1'b1, 1'b0);

    // R10 write and access in same cycle: seg6 at 0xD8000, byte 0x5D low nibble
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'h5D; cfg_wdata = 8'h03;
    chk(10, 32'h000D_8000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(10, 32'h000D_8000, 1'b0, 1'b0, 1'b1);
    chk(10, 32'h000D_8000, 1'b1, 1'b0, 1'b1);

    // R11 writes to unrelated offsets have no effect
    do_reset();
    wr_cfg(8'h58, 8'hFF);
    wr_cfg(8'h60, 8'hFF);
    wr_cfg(8'h71, 8'hFF);
    wr_cfg(8'h73, 8'hFF);
    chk(11, 32'h000F_0000, 1'b0, 1'b0, 1'b0);
    chk(11, 32'h000E_C000, 1'b0, 1'b0, 1'b0);
    chk(11, 32'h000C_0000, 1'b0, 1'b0, 1'b0);
    chk(11, 32'h000A_0000, 1'b0, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule